// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the column address for every beat of a synchronous DRAM burst. When a read or write command is accepted, the controller pulses `cmd_start` and presents three things: the first column, a three-bit burst length code, and the order bit. From the next clock onward, the block puts one column address per cycle on `col_addr`. It also drives a flag that is high while the burst runs, and a second flag that marks the final beat of a fixed-length burst.

Fixed-length bursts stay inside the aligned block whose size is the burst length, so the address bits above that block never change. The order inside the block is either sequential with wrap-around or an XOR pattern of the beat number. A full-page burst walks the whole row modulo 2^COL_W and keeps going until the terminate input ends it. A new `cmd_start` at any cycle abandons the current burst and starts the new one, which allows random column access every clock. Command decoding and the data path are outside this block.

Top module: `burst_col_gen`

## Requirements
- R1: While `rst_n` is low and after its release with no command, `burst_active` and `last_beat` are 0 and `col_addr` is 0.
- R2: The clock edge that samples `cmd_start` high makes `burst_active` 1 and `col_addr` equal to the sampled `start_col`.
- R3: `len_code` selects the burst length: 0 gives 1 beat, 1 gives 2, 2 gives 4, 3 gives 8, and 7 gives full page. Codes 4, 5 and 6 behave as length 1. A fixed burst keeps `burst_active` high for exactly that many cycles.
- R4: With `interleave`=0 and a fixed length L, beat n has the address (start with its low log2(L) bits replaced by (start+n) mod L). The upper bits stay constant.
- R5: With `interleave`=1 and a fixed length L, beat n has the address start XOR n, with n < L.
- R6: A full-page burst (code 7) uses sequential order modulo 2^COL_W whatever the value of `interleave`. It stays active until `term` is seen or a new command arrives.
- R7: `last_beat` is 1 exactly on the final beat of a fixed-length burst. It is never 1 during a full-page burst.
- R8: `term` sampled high without `cmd_start` makes `burst_active` 0 at the next cycle. When both are high, `cmd_start` wins.
- R9: `cmd_start` during an active burst restarts at once from the new `start_col` and uses the new length and order.
- R10: While idle, `col_addr` holds its last value and `last_beat` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_start | input | 1 | Load a new burst |
| start_col | input | COL_W | First column of the burst |
| len_code | input | 3 | Burst length code |
| interleave | input | 1 | 1 selects XOR order, 0 selects sequential |
| term | input | 1 | Burst terminate or precharge |
| col_addr | output | COL_W | Column address of the current beat |
| burst_active | output | 1 | A burst beat is being issued |
| last_beat | output | 1 | Final beat of a fixed-length burst |

## Verification
The bench starts bursts near block edges, for example at column 45 with length 8, where it expects 45..47 and then 40..44. A design that carried into the upper bits would leave the aligned block at that point. It starts a full page at column 254 to check the wrap to 0 without `last_beat`, and it issues interleaved bursts where an adder in place of the XOR would produce the wrong order. Random traffic adds restarts in the middle of a burst, `term` together with `cmd_start`, length-1 bursts and reserved codes. A block that finished a burst one beat early or late, ignored a restart, or let `term` override a new command would fail the check of that cycle.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;
   localparam int unsigned MAX_COL_W = 16;

   localparam logic [2:0] LEN_1    = 3'd0;
   localparam logic [2:0] LEN_2    = 3'd1;
   localparam logic [2:0] LEN_4    = 3'd2;
   localparam logic [2:0] LEN_8    = 3'd3;
   localparam logic [2:0] LEN_PAGE = 3'd7;

   // block mask (length-1) for a fixed-length code; reserved codes act as one beat
   function automatic logic [MAX_COL_W-1:0] fixed_mask(input logic [2:0] code);
      logic [MAX_COL_W-1:0] m;
      case (code)
         LEN_2:   m = MAX_COL_W'(1);
         LEN_4:   m = MAX_COL_W'(3);
         LEN_8:   m = MAX_COL_W'(7);
         default: m = '0;
      endcase
      return m;
   endfunction
endpackage

// File: rtl/burst_len_decode.sv
module burst_len_decode
   import burst_col_pkg::*;
#(
   parameter int unsigned COL_W = 8
) (
   input  logic [2:0]       len_code,
   output logic [COL_W-1:0] blk_mask,
   output logic             page_mode
);
   localparam logic [MAX_COL_W-1:0] PAGE_MASK = MAX_COL_W'((1 << COL_W) - 1);

   logic [MAX_COL_W-1:0] wide_mask;

   always_comb begin
      page_mode = (len_code == LEN_PAGE);
      wide_mask = page_mode ? PAGE_MASK : fixed_mask(len_code);
      blk_mask  = wide_mask[COL_W-1:0];
   end
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
   parameter int unsigned COL_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             stop,
   input  logic [COL_W-1:0] blk_mask,
   input  logic             page_mode,
   output logic [COL_W-1:0] beat,
   output logic             active,
   output logic             final_beat
);
   logic at_end;

   always_comb begin
      at_end     = !page_mode && (beat == blk_mask);
      final_beat = active && at_end;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         beat   <= '0;
         active <= 1'b0;
      end else if (load) begin
         beat   <= '0;
         active <= 1'b1;
      end else if (stop) begin
         active <= 1'b0;
      end else if (active) begin
         if (at_end) active <= 1'b0;
         else        beat   <= beat + COL_W'(1);
      end
   end
endmodule

// File: rtl/burst_addr_map.sv
module burst_addr_map #(
   parameter int unsigned COL_W         = 8,
   parameter bit          INTERLEAVE_EN = 1'b1
) (
   input  logic [COL_W-1:0] base_col,
   input  logic [COL_W-1:0] beat,
   input  logic [COL_W-1:0] blk_mask,
   input  logic             page_mode,
   input  logic             xor_order,
   output logic [COL_W-1:0] col
);
   logic [COL_W-1:0] seq_sum;
   logic             use_xor;

   always_comb seq_sum = base_col + beat;

   generate
      if (INTERLEAVE_EN) begin : g_xor
         always_comb use_xor = xor_order && !page_mode;
      end else begin : g_seq_only
         logic unused_order;
         always_comb begin
            use_xor      = 1'b0;
            unused_order = xor_order;
         end
      end
   endgenerate

   generate
      for (genvar i = 0; i < COL_W; i++) begin : g_bit
         always_comb begin
            if (!blk_mask[i])  col[i] = base_col[i];
            else if (use_xor)  col[i] = base_col[i] ^ beat[i];
            else               col[i] = seq_sum[i];
         end
      end
   endgenerate
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen #(
   parameter int unsigned COL_W         = 8,
   parameter bit          INTERLEAVE_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_start,
   input  logic [COL_W-1:0] start_col,
   input  logic [2:0]       len_code,
   input  logic             interleave,
   input  logic             term,
   output logic [COL_W-1:0] col_addr,
   output logic             burst_active,
   output logic             last_beat
);
   generate
      if (COL_W < 3 || COL_W > burst_col_pkg::MAX_COL_W) begin : g_bad_width
         $error("burst_col_gen: COL_W must lie between 3 and MAX_COL_W");
      end
   endgenerate

   logic [COL_W-1:0] new_mask;
   logic             new_page;
   logic [COL_W-1:0] base_q;
   logic [COL_W-1:0] mask_q;
   logic             page_q;
   logic             ilv_q;
   logic [COL_W-1:0] beat;

   burst_len_decode #(.COL_W(COL_W)) u_dec (
      .len_code  (len_code),
      .blk_mask  (new_mask),
      .page_mode (new_page)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q <= '0;
         mask_q <= '0;
         page_q <= 1'b0;
         ilv_q  <= 1'b0;
      end else if (cmd_start) begin
         base_q <= start_col;
         mask_q <= new_mask;
         page_q <= new_page;
         ilv_q  <= interleave;
      end
   end

   burst_beat_ctr #(.COL_W(COL_W)) u_ctr (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (cmd_start),
      .stop       (term),
      .blk_mask   (mask_q),
      .page_mode  (page_q),
      .beat       (beat),
      .active     (burst_active),
      .final_beat (last_beat)
   );

   burst_addr_map #(.COL_W(COL_W), .INTERLEAVE_EN(INTERLEAVE_EN)) u_map (
      .base_col  (base_q),
      .beat      (beat),
      .blk_mask  (mask_q),
      .page_mode (page_q),
      .xor_order (ilv_q),
      .col       (col_addr)
   );
endmodule

// File: rtl/burst_col_gen_chk.sv
module burst_col_gen_chk #(
   parameter int unsigned COL_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cmd_start,
   input logic [COL_W-1:0] start_col,
   input logic             term,
   input logic [COL_W-1:0] col_addr,
   input logic             burst_active,
   input logic             last_beat,
   input logic [COL_W-1:0] mask_q,
   input logic             page_q,
   input logic             ilv_q
);
   logic going_on;
   always_comb going_on = burst_active && !last_beat && !cmd_start && !term;

   // R2
   load_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_start |=> burst_active && col_addr == $past(start_col));

   // R7
   last_in_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      last_beat |-> burst_active && !page_q);

   // R3
   last_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
      last_beat && !cmd_start |=> !burst_active);

   // R6
   keep_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
      going_on |=> burst_active);

   // R8
   term_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      term && !cmd_start |=> !burst_active);

   // R4
   upper_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      going_on |=> ((col_addr ^ $past(col_addr)) & ~mask_q) == '0);

   // R4
   seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      going_on && (!ilv_q || page_q) |=>
         ((col_addr - $past(col_addr)) & mask_q) == COL_W'(1));

   // R10
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !burst_active && !cmd_start |=> $stable(col_addr) && !last_beat);
endmodule

bind burst_col_gen burst_col_gen_chk #(.COL_W(COL_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cmd_start    (cmd_start),
   .start_col    (start_col),
   .term         (term),
   .col_addr     (col_addr),
   .burst_active (burst_active),
   .last_beat    (last_beat),
   .mask_q       (mask_q),
   .page_q       (page_q),
   .ilv_q        (ilv_q)
);

// File: tb/burst_col_gen_test.sv
module burst_col_gen_test;
   localparam int COL_W = 8;
   localparam int NCOL  = 1 << COL_W;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cmd_start = 1'b0;
   logic [COL_W-1:0] start_col = '0;
   logic [2:0]       len_code = '0;
   logic             interleave = 1'b0;
   logic             term = 1'b0;
   logic [COL_W-1:0] col_addr;
   logic             burst_active;
   logic             last_beat;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   burst_col_gen #(.COL_W(COL_W)) uut (.*);

   // expected state after the next edge
   int    m_start = 0, m_len = 1, m_beat = 0;
   bit    m_page = 0, m_ilv = 0, m_active = 0;
   int    m_last_col = 0;
   string tag = "R1";

   // burst length from the code, per R3 (0 means full page)
   function automatic int code_len(input logic [2:0] c);
      case (c)
         3'd1: return 2;
         3'd2: return 4;
         3'd3: return 8;
         3'd7: return 0;
         default: return 1;
      endcase
   endfunction

   // expected address per R4, R5, R6
   function automatic int exp_col(input int s, input int len, input bit page,
                                  input bit ilv, input int n);
      int blk;
      if (page) return (s + n) % NCOL;
      blk = s - (s % len);
      if (ilv) return s ^ n;
      return blk + ((s + n) % len);
   endfunction

   task automatic chk(input string t, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", t, what, act, exp);
      end
   endtask

   task automatic check_now();
      int ec;
      bit el;
      ec = m_active ? exp_col(m_start, m_len, m_page, m_ilv, m_beat) : m_last_col;
      el = m_active && !m_page && (m_beat == m_len - 1);
      if (m_active) m_last_col = ec;
      chk(tag, "col_addr", int'(col_addr), ec);
      chk((tag == "R4" || tag == "R5" || tag == "R6") ? "R3" : tag,
          "burst_active", int'(burst_active), int'(m_active));
      chk((tag == "R1" || tag == "R8" || tag == "R10") ? tag : "R7",
          "last_beat", int'(last_beat), int'(el));
   endtask

   // check current outputs, then drive one cycle of stimulus and advance the model
   task automatic cycle(input bit st, input int sc, input logic [2:0] code,
                        input bit ilv, input bit tm);
      @(negedge clk);
      check_now();
      cmd_start  = st;
      start_col  = COL_W'(sc);
      len_code   = code;
      interleave = ilv;
      term       = tm;
      if (st) begin
         tag      = m_active ? "R9" : "R2";
         m_start  = sc;
         m_len    = code_len(code);
         m_page   = (m_len == 0);
         if (m_page) m_len = NCOL;
         m_ilv    = ilv;
         m_beat   = 0;
         m_active = 1;
      end else if (tm) begin
         tag      = "R8";
         m_active = 0;
      end else if (m_active) begin
         tag = m_page ? "R6" : (m_ilv ? "R5" : "R4");
         if (!m_page && m_beat == m_len - 1) m_active = 0;
         else m_beat = (m_beat + 1) % NCOL;
      end else begin
         tag = "R10";
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cycle(0, 0, 3'd0, 0, 0);
   endtask

   initial begin
      #(10 * 200000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      int unused_seed;
      unused_seed = $urandom(32'h5eed_0042);
      // R1: reset state
      repeat (3) begin
         @(negedge clk);
         check_now();
      end
      rst_n = 1'b1;
      idle(2);
      // R4: sequential length 8 from 45 -> 45,46,47,40..44
      cycle(1, 45, 3'd3, 0, 0);
      idle(9);
      // R5: interleave length 4 from 45 -> 45,44,47,46
      cycle(1, 45, 3'd2, 1, 0);
      idle(5);
      // R6: full page from 254 wraps to 0, order bit ignored, ends on term (R8)
      cycle(1, 254, 3'd7, 1, 0);
      idle(6);
      cycle(0, 0, 3'd0, 0, 1);
      idle(2);
      // R3: length 1, reserved codes 4..6 and length 2
      cycle(1, 17, 3'd0, 0, 0);
      cycle(1, 9, 3'd4, 1, 0);
      cycle(1, 10, 3'd5, 0, 0);
      cycle(1, 11, 3'd6, 0, 0);
      cycle(1, 13, 3'd1, 1, 0);
      idle(3);
      // R9: restart mid burst; R8: start wins over term
      cycle(1, 100, 3'd3, 0, 0);
      idle(2);
      cycle(1, 200, 3'd2, 1, 1);
      idle(5);
      // R10: idle hold after a burst
      idle(4);
      // mixed random traffic
      for (int i = 0; i < 4000; i++) begin
         bit st, tm, il;
         logic [2:0] cd;
         st = ($urandom % 6) == 0;
         tm = ($urandom % 20) == 0;
         il = $urandom % 2;
         cd = 3'($urandom % 8);
         cycle(st, int'($urandom % NCOL), cd, il, tm);
      end
      idle(2);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule